// File: doc/BRIEF.md
# Bus ready aggregation multiplexer

This block is the readiness and response slice of a pipelined single-manager interconnect with a small number of subordinates. In every address phase it decodes the manager's address against a parameterised table of base/mask windows and raises one address-phase select. When the bus-wide ready is high it registers that decode as the data-phase owner. The data-phase owner's ready, response and read data are then returned as the single bus-wide ready, response and read data. The bus-wide ready goes back to the manager and to every subordinate as an input.

A built-in fallback responder owns every address that no window matches. For an active transfer to an unmapped address it gives a two-cycle error, so the bus never waits on a subordinate that does not exist. For idle or busy transfers to an unmapped address it answers OKAY with no wait. The data-phase owner advances only on ready-high cycles. A subordinate that stretches its data phase therefore holds the whole bus, and the readiness of any subordinate outside its data phase is ignored.

Top module: `bus_ready_agg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the data-phase owner is the fallback responder: bus ready is 1, bus response is OKAY (0) and bus read data is 0.
- R2: Subordinate k matches when (addr & MASK[k]) == BASE[k]. `sub_sel_o` has at most one bit set. When windows overlap, the lowest-numbered matching subordinate wins. When no window matches, `sub_sel_o` is all zero.
- R3: The data-phase owner is the address-phase decode taken at the last rising edge on which bus ready was 1. A change of address in the current cycle does not alter the bus outputs.
- R4: The ready, response and read data inputs of subordinates that are not the data-phase owner have no effect on the bus outputs.
- R5: While bus ready is 0, the data-phase owner holds its value, even if the address-phase decode changes.
- R6: An active transfer (transfer code 2'b10 NONSEQ or 2'b11 SEQ) to an unmapped address gives, in its data phase, one cycle with ready 0 and response ERROR (1), then one cycle with ready 1 and response ERROR. Back-to-back unmapped active transfers repeat this pair.
- R7: An IDLE (2'b00) or BUSY (2'b01) transfer to an unmapped address completes in its first data-phase cycle with ready 1, response OKAY and read data 0.
- R8: Bus response and bus read data come from the same data-phase owner as bus ready, including during that owner's wait cycles.
- R9: In back-to-back transfers to a fast and a slow subordinate, bus ready follows the slow subordinate's ready only during that subordinate's data phase. The ready of the fast subordinate takes effect again from the cycle after the slow one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Address-phase address from the manager |
| trans_i | input | 2 | Address-phase transfer code: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| sub_ready_i | input | NUM_SUB | Ready output of each subordinate |
| sub_resp_i | input | NUM_SUB | Response of each subordinate, 0 OKAY, 1 ERROR |
| sub_rdata_i | input | NUM_SUB*DATA_W | Read data of each subordinate, subordinate k at bits k*DATA_W and up |
| sub_sel_o | output | NUM_SUB | Address-phase select, one bit per subordinate |
| bus_ready_o | output | 1 | Bus-wide ready, fed to the manager and all subordinates |
| bus_resp_o | output | 1 | Bus-wide response |
| bus_rdata_o | output | DATA_W | Bus-wide read data |

## Verification
A stale or wrong data-phase owner shows up within the same cycle. Bus ready, response and read data all switch to a different subordinate's values, so driving every subordinate with different ready levels and distinct read data makes the owner visible at the ports at once. An owner that advances during a wait cycle is seen one cycle later, as read data that jumps to the next subordinate while the slow one still holds ready low. A fallback responder stuck in the wrong state shows as a missing or extra wait cycle, or as an ERROR on an idle transfer, in the first or second cycle of the unmapped data phase.

// File: rtl/bus_ready_pkg.sv
package bus_ready_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic RESP_OKAY = 1'b0;
    localparam logic RESP_ERR  = 1'b1;

    typedef enum logic [1:0] {
        FB_IDLE     = 2'b00,
        FB_ERR_WAIT = 2'b01,
        FB_ERR_DONE = 2'b10
    } fb_state_e;

endpackage

// File: rtl/bus_addr_decode.sv
module bus_addr_decode #(
    parameter int NUM_SUB = 3,
    parameter int ADDR_W  = 32,
    parameter logic [NUM_SUB-1:0][ADDR_W-1:0] BASE = '0,
    parameter logic [NUM_SUB-1:0][ADDR_W-1:0] MASK = '0
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [NUM_SUB-1:0] sel_o,
    output logic               none_o
);

    logic [NUM_SUB-1:0] hit;

    // one comparator per window
    for (genvar k = 0; k < NUM_SUB; k++) begin : g_win
        assign hit[k] = ((addr_i & MASK[k]) == BASE[k]);
    end

    // lowest index wins on overlap
    always_comb begin
        logic taken;
        taken = 1'b0;
        sel_o = '0;
        for (int k = 0; k < NUM_SUB; k++) begin
            if (hit[k] && !taken) begin
                sel_o[k] = 1'b1;
                taken    = 1'b1;
            end
        end
        none_o = !taken;
    end

endmodule

// File: rtl/bus_fallback_sub.sv
module bus_fallback_sub
    import bus_ready_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic [1:0] trans_i,
    input  logic       bus_ready_i,
    output logic       ready_o,
    output logic       resp_o
);

    typedef struct packed {
        fb_state_e st;
    } fb_reg_t;

    fb_reg_t state_d, state_q;
    logic    active;

    assign active = (trans_i == TR_NONSEQ) || (trans_i == TR_SEQ);

    always_comb begin
        state_d = state_q;
        unique case (state_q.st)
            FB_ERR_WAIT: state_d.st = FB_ERR_DONE;
            default: begin
                if (bus_ready_i) begin
                    state_d.st = (sel_i && active) ? FB_ERR_WAIT : FB_IDLE;
                end
            end
        endcase
        ready_o = (state_q.st != FB_ERR_WAIT);
        resp_o  = (state_q.st == FB_IDLE) ? RESP_OKAY : RESP_ERR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{st: FB_IDLE};
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/bus_resp_mux.sv
module bus_resp_mux #(
    parameter int NUM_SUB = 3,
    parameter int DATA_W  = 32,
    parameter int SEL_W   = 2
) (
    input  logic [SEL_W-1:0]          dsel_i,
    input  logic [NUM_SUB-1:0]        sub_ready_i,
    input  logic [NUM_SUB-1:0]        sub_resp_i,
    input  logic [NUM_SUB*DATA_W-1:0] sub_rdata_i,
    input  logic                      fb_ready_i,
    input  logic                      fb_resp_i,
    output logic                      ready_o,
    output logic                      resp_o,
    output logic [DATA_W-1:0]         rdata_o
);

    // fallback responder is the entry selected when no real index matches
    always_comb begin
        ready_o = fb_ready_i;
        resp_o  = fb_resp_i;
        rdata_o = '0;
        for (int k = 0; k < NUM_SUB; k++) begin
            if (dsel_i == SEL_W'(k)) begin
                ready_o = sub_ready_i[k];
                resp_o  = sub_resp_i[k];
                rdata_o = sub_rdata_i[k*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/bus_ready_agg.sv
module bus_ready_agg #(
    parameter int NUM_SUB = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter logic [NUM_SUB-1:0][ADDR_W-1:0] SUB_BASE =
        {32'h0002_0000, 32'h0002_0000, 32'h0000_0000},
    parameter logic [NUM_SUB-1:0][ADDR_W-1:0] SUB_MASK =
        {32'hFFFE_0000, 32'hFFFF_0000, 32'hFFFF_0000}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [1:0]                trans_i,
    input  logic [NUM_SUB-1:0]        sub_ready_i,
    input  logic [NUM_SUB-1:0]        sub_resp_i,
    input  logic [NUM_SUB*DATA_W-1:0] sub_rdata_i,
    output logic [NUM_SUB-1:0]        sub_sel_o,
    output logic                      bus_ready_o,
    output logic                      bus_resp_o,
    output logic [DATA_W-1:0]         bus_rdata_o
);

    localparam int SEL_W = $clog2(NUM_SUB + 1);
    localparam logic [SEL_W-1:0] FB_IDX = SEL_W'(NUM_SUB);

    typedef struct packed {
        logic [SEL_W-1:0] dsel;
    } agg_reg_t;

    agg_reg_t         state_d, state_q;
    logic [SEL_W-1:0] dsel_q;
    logic [SEL_W-1:0] aph_idx;
    logic             no_match;
    logic             fb_ready, fb_resp;

    bus_addr_decode #(
        .NUM_SUB (NUM_SUB),
        .ADDR_W  (ADDR_W),
        .BASE    (SUB_BASE),
        .MASK    (SUB_MASK)
    ) u_dec (
        .addr_i  (addr_i),
        .sel_o   (sub_sel_o),
        .none_o  (no_match)
    );

    bus_fallback_sub u_fb (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (no_match),
        .trans_i     (trans_i),
        .bus_ready_i (bus_ready_o),
        .ready_o     (fb_ready),
        .resp_o      (fb_resp)
    );

    bus_resp_mux #(
        .NUM_SUB (NUM_SUB),
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W)
    ) u_mux (
        .dsel_i      (dsel_q),
        .sub_ready_i (sub_ready_i),
        .sub_resp_i  (sub_resp_i),
        .sub_rdata_i (sub_rdata_i),
        .fb_ready_i  (fb_ready),
        .fb_resp_i   (fb_resp),
        .ready_o     (bus_ready_o),
        .resp_o      (bus_resp_o),
        .rdata_o     (bus_rdata_o)
    );

    assign dsel_q = state_q.dsel;

    // one-hot address-phase select to index; no match means fallback
    always_comb begin
        aph_idx = FB_IDX;
        for (int k = NUM_SUB - 1; k >= 0; k--) begin
            if (sub_sel_o[k]) aph_idx = SEL_W'(k);
        end
    end

    always_comb begin
        state_d = state_q;
        if (bus_ready_o) begin
            state_d.dsel = aph_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{dsel: FB_IDX};
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/bus_ready_agg_chk.sv
module bus_ready_agg_chk #(
    parameter int NUM_SUB = 3,
    parameter int SEL_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SUB-1:0] sub_sel_o,
    input logic [1:0]         trans_i,
    input logic               bus_ready_o,
    input logic               bus_resp_o,
    input logic [SEL_W-1:0]   dsel_q
);

    // R2: never more than one address-phase select
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_sel_o));

    // R5: owner frozen across wait cycles
    a_r5_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready_o |=> $stable(dsel_q));

    // R3: a completed address phase hands ownership to the decoded subordinate
    for (genvar k = 0; k < NUM_SUB; k++) begin : g_own
        a_r3_take_owner: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_ready_o && sub_sel_o[k]) |=> (dsel_q == SEL_W'(k)));
    end

    // R6: unmapped active transfer starts with a wait cycle carrying ERROR
    a_r6_err_first: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready_o && sub_sel_o == '0 && trans_i[1]) |=> (!bus_ready_o && bus_resp_o));

    // R6: ERROR wait is followed by the completing ERROR cycle
    a_r6_err_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready_o && bus_resp_o && dsel_q == SEL_W'(NUM_SUB)) |=> (bus_ready_o && bus_resp_o));

    // R7: unmapped idle/busy completes at once with OKAY
    a_r7_idle_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready_o && sub_sel_o == '0 && !trans_i[1]) |=> (bus_ready_o && !bus_resp_o));

endmodule

bind bus_ready_agg bus_ready_agg_chk #(
    .NUM_SUB (NUM_SUB),
    .SEL_W   (SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sub_sel_o   (sub_sel_o),
    .trans_i     (trans_i),
    .bus_ready_o (bus_ready_o),
    .bus_resp_o  (bus_resp_o),
    .dsel_q      (dsel_q)
);

// File: tb/bus_ready_agg_test.sv
module bus_ready_agg_test;

    localparam int NS = 3;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int NV = 19;
    localparam logic [31:0] UNMAP = 32'h0010_0000;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  trans;
        logic [2:0]  rdy;
        logic [2:0]  resp;
        logic [2:0]  esel;
        logic        erdy;
        logic        eresp;
        logic [31:0] erd;
        logic [3:0]  req;
    } vec_t;

    // data-phase read data of subordinate k is 32'hD000_000k, fallback gives 0
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 2'b10, 3'b111, 3'b000, 3'b001, 1'b1, 1'b0, 32'h0,         4'd1}, // R1 first cycle
        '{32'h0003_0000, 2'b10, 3'b111, 3'b000, 3'b100, 1'b1, 1'b0, 32'hD000_0000, 4'd9}, // R9 fast owner
        '{32'h0000_0100, 2'b10, 3'b011, 3'b000, 3'b001, 1'b0, 1'b0, 32'hD000_0002, 4'd9}, // R9 slow waits
        '{32'h0000_0100, 2'b10, 3'b011, 3'b000, 3'b001, 1'b0, 1'b0, 32'hD000_0002, 4'd5}, // R5 held
        '{32'h0000_0100, 2'b10, 3'b100, 3'b000, 3'b001, 1'b1, 1'b0, 32'hD000_0002, 4'd4}, // R4 others low
        '{32'h0002_0010, 2'b10, 3'b011, 3'b000, 3'b010, 1'b1, 1'b0, 32'hD000_0000, 4'd9}, // R9 slow ignored
        '{32'h0000_0100, 2'b00, 3'b101, 3'b010, 3'b001, 1'b0, 1'b1, 32'hD000_0001, 4'd8}, // R8 resp in wait
        '{32'h0000_0100, 2'b00, 3'b111, 3'b010, 3'b001, 1'b1, 1'b1, 32'hD000_0001, 4'd8}, // R8
        '{UNMAP,         2'b10, 3'b111, 3'b000, 3'b000, 1'b1, 1'b0, 32'hD000_0000, 4'd3}, // R3
        '{32'h0000_0100, 2'b10, 3'b111, 3'b000, 3'b001, 1'b0, 1'b1, 32'h0,         4'd6}, // R6 first
        '{32'h0000_0100, 2'b10, 3'b111, 3'b000, 3'b001, 1'b1, 1'b1, 32'h0,         4'd6}, // R6 second
        '{UNMAP,         2'b00, 3'b111, 3'b000, 3'b000, 1'b1, 1'b0, 32'hD000_0000, 4'd3}, // R3
        '{UNMAP,         2'b01, 3'b111, 3'b000, 3'b000, 1'b1, 1'b0, 32'h0,         4'd7}, // R7 idle
        '{UNMAP,         2'b11, 3'b111, 3'b000, 3'b000, 1'b1, 1'b0, 32'h0,         4'd7}, // R7 busy
        '{UNMAP,         2'b10, 3'b111, 3'b000, 3'b000, 1'b0, 1'b1, 32'h0,         4'd6}, // R6 seq first
        '{UNMAP,         2'b10, 3'b111, 3'b000, 3'b000, 1'b1, 1'b1, 32'h0,         4'd6}, // R6 second
        '{32'h0000_0100, 2'b10, 3'b111, 3'b000, 3'b001, 1'b0, 1'b1, 32'h0,         4'd6}, // R6 back-to-back
        '{32'h0000_0100, 2'b10, 3'b111, 3'b000, 3'b001, 1'b1, 1'b1, 32'h0,         4'd6}, // R6
        '{32'h0000_0100, 2'b10, 3'b110, 3'b000, 3'b001, 1'b0, 1'b0, 32'hD000_0000, 4'd3}  // R3 owner sub0
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [AW-1:0]        addr_i = UNMAP;
    logic [1:0]           trans_i = 2'b00;
    logic [NS-1:0]        sub_ready_i = '1;
    logic [NS-1:0]        sub_resp_i = '0;
    logic [NS*DW-1:0]     sub_rdata_i;
    logic [NS-1:0]        sub_sel_o;
    logic                 bus_ready_o;
    logic                 bus_resp_o;
    logic [DW-1:0]        bus_rdata_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign sub_rdata_i = {32'hD000_0002, 32'hD000_0001, 32'hD000_0000};

    always #10 clk = ~clk;

    bus_ready_agg uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .trans_i     (trans_i),
        .sub_ready_i (sub_ready_i),
        .sub_resp_i  (sub_resp_i),
        .sub_rdata_i (sub_rdata_i),
        .sub_sel_o   (sub_sel_o),
        .bus_ready_o (bus_ready_o),
        .bus_resp_o  (bus_resp_o),
        .bus_rdata_o (bus_rdata_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin : stim
        repeat (2) @(negedge clk);
        // R1: values while reset held
        #5;
        chk("R1 ready in reset", 32'(bus_ready_o), 32'd1);
        chk("R1 resp in reset", 32'(bus_resp_o), 32'd0);
        chk("R1 rdata in reset", bus_rdata_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            addr_i      = VECS[i].addr;
            trans_i     = VECS[i].trans;
            sub_ready_i = VECS[i].rdy;
            sub_resp_i  = VECS[i].resp;
            #5;
            chk($sformatf("R%0d v%0d sel", (VECS[i].req == 4'd1) ? 2 : VECS[i].req, i),
                32'(sub_sel_o), 32'(VECS[i].esel));
            chk($sformatf("R%0d v%0d ready", VECS[i].req, i), 32'(bus_ready_o), 32'(VECS[i].erdy));
            chk($sformatf("R%0d v%0d resp", VECS[i].req, i), 32'(bus_resp_o), 32'(VECS[i].eresp));
            chk($sformatf("R%0d v%0d rdata", VECS[i].req, i), bus_rdata_o, VECS[i].erd);
            @(negedge clk);
        end

        // R2: decode boundaries and overlap priority
        addr_i = 32'h0000_FFFF; #1; chk("R2 top of win0", 32'(sub_sel_o), 32'b001);
        addr_i = 32'h0001_0000; #1; chk("R2 gap", 32'(sub_sel_o), 32'b000);
        addr_i = 32'h0002_FFFF; #1; chk("R2 overlap first wins", 32'(sub_sel_o), 32'b010);
        addr_i = 32'h0003_0004; #1; chk("R2 win2 only", 32'(sub_sel_o), 32'b100);
        addr_i = 32'h0004_0000; #1; chk("R2 above map", 32'(sub_sel_o), 32'b000);

        // R1: reset taken in the middle of a slow wait
        @(negedge clk);
        addr_i = 32'h0003_0000; trans_i = 2'b10; sub_ready_i = 3'b111;
        @(negedge clk);
        sub_ready_i = 3'b011; addr_i = 32'h0000_0100;
        #5;
        chk("R5 slow owner waits", 32'(bus_ready_o), 32'd0);
        @(negedge clk);
        chk("R5 owner still slow", bus_rdata_o, 32'hD000_0002);
        rst_n = 1'b0;
        #2;
        chk("R1 ready after mid reset", 32'(bus_ready_o), 32'd1);
        chk("R1 rdata after mid reset", bus_rdata_o, 32'd0);
        chk("R1 resp after mid reset", 32'(bus_resp_o), 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule